// File: doc/BRIEF.md
# Sync-Pulse Clock Divider Aligner

This block divides a fast converter-rate clock down to a data-rate clock enable through an integer counter whose ratio is 1, 2, 4 or 8. A shared synchronization input lets several identical copies of the block, all clocked by the same fast clock and fed the same sync signal, bring their counters to the same phase. Once that happens, every copy raises its data-clock enable in the same fast-clock cycle.

The sync input goes through a two-flop synchronizer, and then through a rising-edge detector gated by an enable bit. An accepted edge clears the phase counter and loads the pending ratio setting. The realignment therefore always happens at a fixed distance from the first fast-clock edge that samples the sync input high.

The sync input may be a single pulse or a periodic train. A train whose period is a whole multiple of the data-clock period lands on phase zero every time, so it leaves an aligned counter undisturbed.

Top module: `sync_clkdiv_aligner`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, the block reaches its reset state after that edge. In that state `phase_cnt` is 0, `dclk_en` is 1 and `sync_seen` is 0, and the ratio present on `ratio_sel` becomes the active ratio.
- R2: With no accepted sync edge, `phase_cnt` counts 0, 1, …, N−1 and wraps back to 0, where N is the active ratio. `dclk_en` is 1 exactly in the cycles where `phase_cnt` is 0.
- R3: `ratio_sel` encodes N as 2 to the power of its value: 0 selects 1, 1 selects 2, 2 selects 4 and 3 selects 8. A new value takes effect only at reset or at an accepted sync edge, and is ignored at all other times.
- R4: `sync_in` is sampled on the rising edge of `clk`. Let edge k be the first edge that samples it high after it was sampled low. If `sync_en` is high at edge k+2, then after edge k+2 `phase_cnt` is 0 and `dclk_en` is 1. After edge k+2+j, `phase_cnt` is j mod N.
- R5: `sync_seen` is 1 for exactly the one cycle that follows an accepted realignment edge. A `sync_in` held high for many cycles gives one accepted edge only.
- R6: When `sync_en` is low at edge k+2, the rising edge of `sync_in` is ignored. `phase_cnt`, `dclk_en` and `sync_seen` continue exactly as under R2.
- R7: When a periodic `sync_in` train has a period that is a multiple of N and is already aligned, each pulse lands on phase 0. The `dclk_en` pattern is then identical to free running, with no extra or missing pulse.
- R8: `phase_cnt` only ever leaves 0 by incrementing by one per cycle, so no value is skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast converter-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Raw synchronization input (pulse or periodic train) |
| sync_en | input | 1 | Accept sync edges when high |
| ratio_sel | input | 2 | Pending divide-ratio code, N = 2^ratio_sel |
| dclk_en | output | 1 | Data-clock enable, high once per N cycles |
| phase_cnt | output | 3 | Current divider phase |
| sync_seen | output | 1 | One-cycle flag for an accepted sync edge |

## Verification
Every output is a register, so the result of the inputs applied before a rising edge can be seen after that same edge. The exception is a sync edge, which acts at the second edge after the edge that first samples it high: two synchronizer stages come first. The bench drives the inputs on falling edges and pushes the expected outputs for each rising edge into a queue. Its reference model delays the sync samples by the same three registers. The monitor compares on the next falling edge, so every comparison lands in the cycle where the result is due, and the two-cycle offset of R4 comes from the model and not from a guess.

// File: rtl/sca_pkg.sv
package sca_pkg;

  // Terminal phase value for a power-of-two ratio code.
  function automatic int unsigned last_phase(input int unsigned code);
    return (32'd1 << code) - 32'd1;
  endfunction

endpackage

// File: rtl/sca_sync_stage.sv
module sca_sync_stage #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    genvar i;
    for (i = 0; i < STAGES; i++) begin : g_flop
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/sca_rise_detect.sv
module sca_rise_detect (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic arm,
  output logic pulse
);

  logic prev_q;

  // History tracks the level even while disarmed, so enabling during a
  // high level never manufactures an edge.
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign pulse = lvl & ~prev_q & arm;

endmodule

// File: rtl/sca_phase_counter.sv
module sca_phase_counter #(
  parameter int SEL_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             load,
  output logic [CNT_W-1:0] cnt,
  output logic             tick,
  output logic             seen
);

  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] lim_new;
  logic [CNT_W-1:0] cnt_nxt;
  logic             wrap;

  always_comb begin
    lim_new = CNT_W'(sca_pkg::last_phase(32'(sel)));
    wrap    = (cnt >= lim_q);
    cnt_nxt = wrap ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_q <= lim_new;
      cnt   <= '0;
      tick  <= 1'b1;
      seen  <= 1'b0;
    end else if (load) begin
      lim_q <= lim_new;
      cnt   <= '0;
      tick  <= 1'b1;
      seen  <= 1'b1;
    end else begin
      cnt  <= cnt_nxt;
      tick <= wrap;
      seen <= 1'b0;
    end
  end

endmodule

// File: rtl/sync_clkdiv_aligner.sv
module sync_clkdiv_aligner #(
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_in,
  input  logic             sync_en,
  input  logic [SEL_W-1:0] ratio_sel,
  output logic             dclk_en,
  output logic [(1<<SEL_W)-2:0] phase_cnt,
  output logic             sync_seen
);

  localparam int CNT_W = (1 << SEL_W) - 1;

  logic sync_meta_out;
  logic accept;

  sca_sync_stage #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (sync_in),
    .q   (sync_meta_out)
  );

  sca_rise_detect u_edge (
    .clk   (clk),
    .rst   (rst),
    .lvl   (sync_meta_out),
    .arm   (sync_en),
    .pulse (accept)
  );

  sca_phase_counter #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .sel  (ratio_sel),
    .load (accept),
    .cnt  (phase_cnt),
    .tick (dclk_en),
    .seen (sync_seen)
  );

endmodule

// File: rtl/sync_clkdiv_aligner_chk.sv
module sync_clkdiv_aligner_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             sync_en,
  input logic             dclk_en,
  input logic [CNT_W-1:0] phase_cnt,
  input logic             sync_seen
);

  AST_EN_AT_PHASE_ZERO: assert property (@(posedge clk) disable iff (rst)
    dclk_en == (phase_cnt == '0)); // R2

  AST_SEEN_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sync_seen |=> !sync_seen); // R5

  AST_SEEN_ALIGNS: assert property (@(posedge clk) disable iff (rst)
    sync_seen |-> (phase_cnt == '0) && dclk_en); // R4

  AST_SEEN_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    sync_seen |-> $past(sync_en)); // R6

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    (!sync_seen && phase_cnt != '0) |-> phase_cnt == $past(phase_cnt) + 1'b1); // R8

endmodule

bind sync_clkdiv_aligner sync_clkdiv_aligner_chk #(.CNT_W((1<<SEL_W)-1)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sync_en   (sync_en),
  .dclk_en   (dclk_en),
  .phase_cnt (phase_cnt),
  .sync_seen (sync_seen)
);

// File: tb/sync_clkdiv_aligner_test.sv
module sync_clkdiv_aligner_test;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sync_in = 1'b0;
  logic       sync_en = 1'b0;
  logic [1:0] ratio_sel = 2'd2;
  logic       dclk_en;
  logic [2:0] phase_cnt;
  logic       sync_seen;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  typedef struct {
    logic [2:0] ph;
    logic       en;
    logic       seen;
    string      tag;
  } exp_t;

  exp_t sb[$];

  // Reference model state, built from the requirements.
  bit m_s1, m_s2, m_s3;
  int m_cnt, m_n;
  bit m_seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_clkdiv_aligner uut (
    .clk(clk), .rst(rst), .sync_in(sync_in), .sync_en(sync_en),
    .ratio_sel(ratio_sel), .dclk_en(dclk_en), .phase_cnt(phase_cnt),
    .sync_seen(sync_seen)
  );

  task automatic step(input bit r, input bit s, input bit e,
                      input logic [1:0] sel, input string tag);
    exp_t it;
    bit evt;
    @(negedge clk);
    rst = r; sync_in = s; sync_en = e; ratio_sel = sel;
    @(posedge clk);
    #1;
    if (r) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
      m_cnt = 0; m_n = 1 << sel; m_seen = 0;
    end else begin
      evt = m_s2 && !m_s3 && e;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = s;
      if (evt) begin
        m_cnt = 0; m_n = 1 << sel; m_seen = 1;
      end else begin
        m_cnt = (m_cnt + 1) % m_n; m_seen = 0;
      end
    end
    it.ph = 3'(m_cnt); it.en = (m_cnt == 0); it.seen = m_seen; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic run(input int n, input bit s, input bit e,
                     input logic [1:0] sel, input string tag);
    for (int i = 0; i < n; i++) step(0, s, e, sel, tag);
  endtask

  // Monitor: compares one queued item per cycle, away from the active edge.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      vectors++;
      if (phase_cnt !== it.ph || dclk_en !== it.en || sync_seen !== it.seen) begin
        misses++;
        $display("FAIL %s: phase=%0d en=%0b seen=%0b expected phase=%0d en=%0b seen=%0b",
                 it.tag, phase_cnt, dclk_en, sync_seen, it.ph, it.en, it.seen);
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
    end
  end

  initial begin
    // R1: reset state, ratio 4 captured
    for (int i = 0; i < 3; i++) step(1, 0, 1, 2'd2, "R1");
    // R2: free running at N=4
    run(16, 0, 1, 2'd2, "R2");
    // R3: new code without sync is ignored
    run(12, 0, 1, 2'd3, "R3");
    // R4/R5: single pulse aligns and loads N=8
    step(0, 1, 1, 2'd3, "R4");
    run(3, 0, 1, 2'd3, "R5");
    run(14, 0, 1, 2'd3, "R4");
    // R6: edge with sync disabled is ignored
    step(0, 1, 0, 2'd1, "R6");
    run(14, 0, 0, 2'd1, "R6");
    // R5: held-high sync accepted once, N=2 loaded
    run(20, 1, 1, 2'd1, "R5");
    run(6, 0, 1, 2'd1, "R3");
    // R7: periodic train, period 16, multiple of N=8
    step(0, 1, 1, 2'd3, "R7");
    run(15, 0, 1, 2'd3, "R7");
    for (int p = 0; p < 4; p++) begin
      step(0, 1, 1, 2'd3, "R7");
      run(15, 0, 1, 2'd3, "R7");
    end
    // R3: divide by 1, enable every cycle
    step(0, 1, 1, 2'd0, "R3");
    run(10, 0, 1, 2'd0, "R3");
    // R8: misaligned pulse while N=1 loads N=8, counter restarts cleanly
    step(0, 1, 1, 2'd3, "R8");
    run(5, 0, 1, 2'd3, "R8");
    step(0, 1, 1, 2'd3, "R8");
    run(12, 0, 1, 2'd3, "R8");
    // R1: reset again mid-count
    step(1, 0, 1, 2'd1, "R1");
    run(6, 0, 1, 2'd1, "R2");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    summary();
  end

endmodule